// File: doc/BRIEF.md
# Serial ADC Frame and Power-Mode Controller

This block models the digital side of a 12-bit serial sampling converter. It watches an active-low chip select and a serial clock, both sampled on a fast system clock. It counts serial-clock falling edges within each frame and shifts a 16-bit output word onto a data line that can be tri-stated. The conversion value arrives on a parallel input and is captured when chip select falls.

The power mode is set by the falling-edge window in which chip select rises. A rise after only a few edges is treated as noise and leaves the mode alone. A rise in the middle window aborts the frame and puts the device into shutdown. A rise late in the frame truncates the word and keeps the device in normal mode. A frame that starts in shutdown acts as the power-up conversion, and its word is flagged as not valid. The device commits to normal mode only when that frame reaches its 10th falling edge.

Top module: `adc_serial_fsm`

## Requirements
- R1: After reset the data line is undriven (`sdata_oe` low), `mode_normal` is 0 (shutdown) and `word_valid` is 0.
- R2: A falling chip select starts a frame and drives the data line. The word is 16 bits: three 0 bits, then the 12 captured bits MSB first, then one 0 bit. Before the first falling edge of `sclk` the line carries word bit 15. After falling edge k (1..15) it carries word bit 15-k.
- R3: After the 16th falling edge the data line is undriven. It stays undriven while chip select remains low, whatever `sclk` does. Only a rise followed by a fall of chip select starts the next frame.
- R4: If chip select rises after fewer than 2 falling edges, `mode_normal` keeps its value and the line is undriven.
- R5: If chip select rises after 2 to 9 falling edges, the frame aborts, the line is undriven and `mode_normal` becomes 0.
- R6: If chip select rises after 10 to 15 falling edges, the word is truncated, the line is undriven and `mode_normal` is 1.
- R7: In a frame, `mode_normal` does not change before the 10th falling edge. At the 10th falling edge it becomes 1, even for a frame that started in shutdown.
- R8: During a frame, `word_valid` equals the value `mode_normal` had when the frame started. It is 0 while chip select is high.
- R9: `sample_in` is captured at the start of the frame. Changing it during the frame has no effect on the shifted word.
- R10: Falling edges of `sclk` while chip select is high neither drive the line nor change the mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the serial pins |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Active-low chip select |
| sclk | input | 1 | Serial clock; the word advances on its falling edges |
| sample_in | input | 12 | Conversion result, captured when a frame starts |
| sdata | output | 1 | Serial data; high impedance when not driven |
| sdata_oe | output | 1 | High while `sdata` is driven |
| mode_normal | output | 1 | 1 = normal mode, 0 = shutdown |
| word_valid | output | 1 | 1 while the current frame's word is a valid conversion |

## Verification
Every chip-select release point from 0 to 16 falling edges is tried from both starting modes. This separates the noise-guard window, the shutdown window and the truncation window at each of their boundary edges (1/2, 9/10, 15/16). Each frame uses a different data pattern: all ones, all zeros and computed mixtures. The pattern is inverted on the input mid-frame, so an error in bit order, in the padding bits or in the capture instant shows up as a wrong bit on a particular edge. The frames that start in shutdown distinguish the dummy power-up word from a valid one. Runs of serial-clock pulses with chip select high, and runs held low past the end of the word, show that stray edges are ignored.

// File: rtl/adc_serial_fsm.sv
module adc_serial_fsm #(
  parameter int DW      = 12,
  parameter int LEAD    = 3,
  parameter int FW      = 16,
  parameter int SHUT_LO = 2,
  parameter int SHUT_HI = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          sclk,
  input  logic [DW-1:0] sample_in,
  output logic          sdata,
  output logic          sdata_oe,
  output logic          mode_normal,
  output logic          word_valid
);
  localparam int CW    = $clog2(FW + 1);
  localparam int TRAIL = FW - LEAD - DW;
  localparam logic [CW-1:0] FULL = CW'(FW);
  localparam logic [CW-1:0] LO   = CW'(SHUT_LO);
  localparam logic [CW-1:0] HI   = CW'(SHUT_HI);

  logic          cs_q, sclk_q, active, mode_q, valid_q;
  logic [CW-1:0] cnt;
  logic [FW-1:0] shreg;

  wire cs_fall  = cs_q & ~cs_n;
  wire cs_rise  = ~cs_q & cs_n;
  wire sck_fall = sclk_q & ~sclk & ~cs_n & active & ~cs_fall;
  wire [FW-1:0] word = {{LEAD{1'b0}}, sample_in, {TRAIL{1'b0}}};

  assign sdata_oe    = active & (cnt != FULL);
  assign sdata       = sdata_oe ? shreg[FW-1] : 1'bz;
  assign mode_normal = mode_q;
  assign word_valid  = valid_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cs_q    <= 1'b1;
      sclk_q  <= 1'b0;
      active  <= 1'b0;
      cnt     <= '0;
      shreg   <= '0;
      mode_q  <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      cs_q   <= cs_n;
      sclk_q <= sclk;
      if (cs_fall) begin
        active  <= 1'b1;
        cnt     <= '0;
        shreg   <= word;
        valid_q <= mode_q;
      end else if (cs_n) begin
        active  <= 1'b0;
        cnt     <= '0;
        valid_q <= 1'b0;
        if (cs_rise && active && cnt >= LO && cnt < HI)
          mode_q <= 1'b0;
      end else if (sck_fall && cnt != FULL) begin
        cnt   <= cnt + 1'b1;
        shreg <= {shreg[FW-2:0], 1'b0};
        if (cnt == HI - 1'b1)
          mode_q <= 1'b1;
      end
    end
  end

  // R3
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= FULL);

  // R3
  held_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sdata_oe && active && !cs_n) |=> !sdata_oe);

  // R5
  shut_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && active && cnt >= LO && cnt < HI) |=> (!mode_normal && !sdata_oe));

  // R4
  noise_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && active && cnt < LO) |=> $stable(mode_normal));

  // R7
  wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sck_fall && cnt == HI - 1'b1) |=> mode_normal);

  // R8
  valid_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_fall |=> (word_valid == $past(mode_normal)));

  // R10
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && cs_q) |=> (!sdata_oe && $stable(mode_normal)));
endmodule

// File: tb/adc_serial_fsm_test.sv
module adc_serial_fsm_test;
  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sclk = 1'b0;
  logic [11:0] sample_in = '0;
  logic sdata, sdata_oe, mode_normal, word_valid;
  int checks = 0, failures = 0;
  bit exp_mode = 1'b0;

  always #2 clk = ~clk;

  adc_serial_fsm uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sample_in(sample_in),
    .sdata(sdata), .sdata_oe(sdata_oe), .mode_normal(mode_normal), .word_valid(word_valid)
  );

  task automatic chk(input bit ok, input string req, input logic act, input logic exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic wbit(input logic [11:0] d, input int k);
    logic [15:0] w;
    w = {3'b000, d, 1'b0};
    return w[15 - k];
  endfunction

  task automatic pulse();
    sclk = 1'b1; @(negedge clk);
    sclk = 1'b0; @(negedge clk);
  endtask

  task automatic frame(input logic [11:0] d, input int n);
    bit start_mode;
    start_mode = exp_mode;
    sample_in = d; cs_n = 1'b0; @(negedge clk);
    chk(sdata_oe === 1'b1, "R2 oe at start", sdata_oe, 1'b1);
    chk(sdata === wbit(d, 0), "R2 bit0", sdata, wbit(d, 0));
    chk(word_valid === start_mode, "R8 valid", word_valid, start_mode);
    sample_in = ~d;
    for (int k = 1; k <= n; k++) begin
      pulse();
      if (k < 16) begin
        chk(sdata_oe === 1'b1, "R2 oe", sdata_oe, 1'b1);
        chk(sdata === wbit(d, k), "R2/R9 bit", sdata, wbit(d, k));
      end else
        chk(sdata_oe === 1'b0, "R3 end", sdata_oe, 1'b0);
      if (k < 10)
        chk(mode_normal === start_mode, "R7 hold", mode_normal, start_mode);
      else
        chk(mode_normal === 1'b1, "R7 commit", mode_normal, 1'b1);
    end
    if (n >= 16) begin
      for (int j = 0; j < 3; j++) begin
        pulse();
        chk(sdata_oe === 1'b0, "R3 held low", sdata_oe, 1'b0);
      end
    end
    cs_n = 1'b1; @(negedge clk);
    if (n >= 10) exp_mode = 1'b1;
    else if (n >= 2) exp_mode = 1'b0;
    if (n < 2) chk(mode_normal === exp_mode, "R4 mode", mode_normal, exp_mode);
    else if (n < 10) chk(mode_normal === exp_mode, "R5 mode", mode_normal, exp_mode);
    else chk(mode_normal === exp_mode, "R6 mode", mode_normal, exp_mode);
    chk(sdata_oe === 1'b0, "R5/R6 hiz", sdata_oe, 1'b0);
    chk(word_valid === 1'b0, "R8 idle", word_valid, 1'b0);
    @(negedge clk);
  endtask

  initial begin
    #400000;
    failures++; checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [11:0] p;
    repeat (3) @(negedge clk);
    rst_n = 1'b1; @(negedge clk);
    // R1
    chk(sdata_oe === 1'b0, "R1 oe", sdata_oe, 1'b0);
    chk(mode_normal === 1'b0, "R1 mode", mode_normal, 1'b0);
    chk(word_valid === 1'b0, "R1 valid", word_valid, 1'b0);
    // R10
    for (int j = 0; j < 6; j++) begin
      pulse();
      chk(sdata_oe === 1'b0, "R10 oe", sdata_oe, 1'b0);
      chk(mode_normal === exp_mode, "R10 mode", mode_normal, exp_mode);
    end
    for (int s = 0; s < 2; s++) begin
      for (int n = 0; n <= 16; n++) begin
        for (int i = 0; i < 4; i++) begin
          if (i == 0) p = 12'hFFF;
          else if (i == 1) p = 12'h000;
          else p = 12'((n * 37 + i * 1365 + s * 291) * 7);
          if (s == 1) frame(~p, 16);
          else frame(p, 5);
          frame(p, n);
        end
      end
    end
    frame(12'h3C5, 16);
    for (int j = 0; j < 4; j++) begin
      pulse();
      chk(sdata_oe === 1'b0, "R10 idle oe", sdata_oe, 1'b0);
      chk(mode_normal === 1'b1, "R10 idle mode", mode_normal, 1'b1);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule